// File: doc/BRIEF.md
# Oscillator DAC Centering Calibrator

This block runs the centering routine for the control DAC of a voltage-controlled oscillator, one pass per data-rate zone. On a start pulse it works through the zones in ascending order. For each zone it presents that zone's numerator and denominator divider values with a one-cycle load strobe. It then writes a nominal DAC code and waits a programmable settling time. After that it samples a single comparator bit that tells whether the oscillator control voltage is above its midpoint.

After the first sample the block moves the code by one LSB in the direction that opposes the comparator. It writes the new code, waits the settling time and samples again. It keeps doing this until the comparator reads the opposite polarity from its first sample. The code in place when the polarity flips is stored as that zone's calibrated setting. If the code reaches either end of its range before a flip, the rail code is stored and an error flag is set for that zone. A single done pulse follows the last zone.

Results sit in a small per-zone bank that is read combinationally. The routine can be started again at any later time to refresh the bank.

Top module: `vco_dac_centering_cal`

## Requirements
- R1: A start pulse seen while idle captures the settling count and nominal code. In the next cycle busy is high and the rate load strobe pulses with zone 0's numerator and denominator. A start pulse seen while busy is ignored.
- R2: In the cycle after every rate load strobe, the DAC write strobe pulses with the captured nominal code on the DAC output.
- R3: After each sample that does not end the zone, the next DAC write carries the previous code minus one if the comparator read high, or plus one if it read low.
- R4: With a settling count N, each comparator sample is taken N+2 clock edges after the edge that wrote the DAC code. Within a zone, consecutive DAC write strobes are therefore exactly N+2 cycles apart.
- R5: When a sample differs in polarity from the zone's first sample, the current code is stored as the zone's result with its error flag clear, and no further write is made in that zone.
- R6: If a step would take the code below 0 or above 2^DAC_W-1, the block makes no write and stores the rail code (0 or all ones) with the zone's error flag set. This includes the first sample taken at the nominal code.
- R7: Zones are calibrated in order 0 to NUM_ZONES-1. The rate load strobe for zone k+1 comes in the cycle after zone k's result is stored, and zone z's numerator and denominator are the z-th RATE_W-bit fields of the rate inputs, with field 0 in the least significant bits.
- R8: One cycle after the last zone's result is stored, done is high for exactly one cycle and busy is low in that same cycle.
- R9: The result bank returns the code and error flag of the zone selected by the read index in the same cycle. Reset clears every entry to code 0 with the flag clear, and a later run overwrites each entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a full calibration run |
| settle_cycles_i | input | SETTLE_W | Settling count N, captured at start |
| nominal_code_i | input | DAC_W | Nominal DAC code, captured at start |
| rate_num_tab_i | input | NUM_ZONES*RATE_W | Per-zone numerator values, zone 0 in the low field |
| rate_den_tab_i | input | NUM_ZONES*RATE_W | Per-zone denominator values, zone 0 in the low field |
| cmp_above_i | input | 1 | Comparator bit, high when the control voltage is above midpoint |
| rd_zone_i | input | ZONE_W | Result bank read index |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse after the last zone is stored |
| rate_load_o | output | 1 | Divider value load strobe |
| rate_num_o | output | RATE_W | Numerator for the zone being loaded |
| rate_den_o | output | RATE_W | Denominator for the zone being loaded |
| dac_wr_o | output | 1 | DAC write strobe |
| dac_code_o | output | DAC_W | DAC code |
| rd_code_o | output | DAC_W | Stored calibrated code of the selected zone |
| rd_err_o | output | 1 | Rail error flag of the selected zone |

## Verification
Every output is due at a fixed cycle offset. Busy and the first rate load come one cycle after the start edge. The nominal write comes one cycle after each load. Each stepped write comes N+2 cycles after the write before it. The next zone's load or the done pulse comes one cycle after the deciding sample. The bench numbers every cycle from the start pulse and samples on the falling edge. It keeps the cycle of the last load and the last write, so every strobe is checked against the exact offset it must arrive at rather than a tolerance window. A comparator model driven by the DAC output supplies a per-zone threshold. From it the bench computes the expected code sequence, write count, stored code and error flag for each zone, including nominal codes that start on a rail.

// File: rtl/cal_pkg.sv
// Package: shared types for the oscillator DAC centering calibrator.
// Assumes: nothing beyond standard SystemVerilog.
package cal_pkg;

    // Sequencer states of the calibration controller.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_NOMINAL = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_SAMPLE  = 2'd3
    } cal_state_t;

endpackage

// File: rtl/cal_settle_timer.sv
// Module: settling timer. It is loaded with a count on every DAC write and
// counts down to zero. expired_o is high while the count is zero.
// Assumes: the controller loads the timer on the same edge as each DAC write.
module cal_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load on a DAC write, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired_o = (cnt_q == '0);

    // R4: an unloaded, non-zero count drops by exactly one per cycle.
    a_r4_settle_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) != '0 && !$past(load_i)) |-> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/cal_step_unit.sv
// Module: step decision logic. From the current code and the comparator bit it
// produces the one-LSB next code, a polarity-flip flag and a rail flag.
// Assumes: ref_valid_i is low for the first sample of a zone.
module cal_step_unit #(
    parameter int DAC_W = 8
) (
    input  logic [DAC_W-1:0] code_i,
    input  logic             above_i,
    input  logic             ref_valid_i,
    input  logic             ref_above_i,
    output logic [DAC_W-1:0] next_code_o,
    output logic             flip_o,
    output logic             rail_o
);

    localparam logic [DAC_W-1:0] CODE_MAX = {DAC_W{1'b1}};

    logic at_floor;
    logic at_ceiling;

    // Decide the direction and detect a flip or a blocked step.
    always_comb begin
        at_floor    = (code_i == '0);
        at_ceiling  = (code_i == CODE_MAX);
        flip_o      = ref_valid_i && (above_i != ref_above_i);
        rail_o      = !flip_o && (above_i ? at_floor : at_ceiling);
        next_code_o = above_i ? (code_i - DAC_W'(1)) : (code_i + DAC_W'(1));
    end

endmodule

// File: rtl/cal_result_bank.sv
// Module: per-zone result storage, one code and one error flag per zone,
// written by the controller and read combinationally.
// Assumes: at most one write per cycle; out-of-range reads return zero.
module cal_result_bank #(
    parameter int NUM_ZONES = 4,
    parameter int DAC_W     = 8,
    parameter int ZONE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ZONE_W-1:0] wr_zone_i,
    input  logic [DAC_W-1:0]  wr_code_i,
    input  logic              wr_err_i,
    input  logic [ZONE_W-1:0] rd_zone_i,
    output logic [DAC_W-1:0]  rd_code_o,
    output logic              rd_err_o
);

    localparam logic [DAC_W-1:0] CODE_MAX = {DAC_W{1'b1}};

    logic [DAC_W-1:0] code_mem [NUM_ZONES];
    logic             err_mem  [NUM_ZONES];

    // Clear on reset, then write the addressed zone's entry.
    always_ff @(posedge clk) begin
        for (int z = 0; z < NUM_ZONES; z++) begin
            if (!rst_n) begin
                code_mem[z] <= '0;
                err_mem[z]  <= 1'b0;
            end else if (wr_en_i && (32'(wr_zone_i) == z)) begin
                code_mem[z] <= wr_code_i;
                err_mem[z]  <= wr_err_i;
            end
        end
    end

    // Combinational read port.
    always_comb begin
        rd_code_o = '0;
        rd_err_o  = 1'b0;
        for (int z = 0; z < NUM_ZONES; z++) begin
            if (32'(rd_zone_i) == z) begin
                rd_code_o = code_mem[z];
                rd_err_o  = err_mem[z];
            end
        end
    end

    // R6: an error entry always carries a rail code.
    a_r6_err_on_rail: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_err_i) |-> (wr_code_i == '0 || wr_code_i == CODE_MAX));

    // R7: writes only address existing zones.
    a_r7_zone_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (32'(wr_zone_i) < NUM_ZONES));

endmodule

// File: rtl/vco_dac_centering_cal.sv
// Module: top of the oscillator DAC centering calibrator. It sequences the zones,
// loads the divider values, writes the nominal code, and steps one LSB per
// settled comparator sample until the polarity flips or a rail is hit. Each
// outcome is stored in the result bank.
// Assumes: the comparator is valid after the programmed settling time; the
// rate inputs stay stable during a run.
module vco_dac_centering_cal #(
    parameter int NUM_ZONES = 4,
    parameter int DAC_W     = 8,
    parameter int RATE_W    = 8,
    parameter int SETTLE_W  = 8,
    parameter int ZONE_W    = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [SETTLE_W-1:0]         settle_cycles_i,
    input  logic [DAC_W-1:0]            nominal_code_i,
    input  logic [NUM_ZONES*RATE_W-1:0] rate_num_tab_i,
    input  logic [NUM_ZONES*RATE_W-1:0] rate_den_tab_i,
    input  logic                        cmp_above_i,
    input  logic [ZONE_W-1:0]           rd_zone_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        rate_load_o,
    output logic [RATE_W-1:0]           rate_num_o,
    output logic [RATE_W-1:0]           rate_den_o,
    output logic                        dac_wr_o,
    output logic [DAC_W-1:0]            dac_code_o,
    output logic [DAC_W-1:0]            rd_code_o,
    output logic                        rd_err_o
);

    import cal_pkg::*;

    localparam logic [ZONE_W-1:0] LAST_ZONE = ZONE_W'(NUM_ZONES - 1);

    cal_state_t          state_q;
    logic [ZONE_W-1:0]   zone_q;
    logic [ZONE_W-1:0]   zone_nxt;
    logic [DAC_W-1:0]    code_q;
    logic [DAC_W-1:0]    nominal_q;
    logic [SETTLE_W-1:0] settle_q;
    logic                dac_wr_q;
    logic                load_q;
    logic [RATE_W-1:0]   num_q;
    logic [RATE_W-1:0]   den_q;
    logic                busy_q;
    logic                done_q;
    logic                ref_valid_q;
    logic                ref_above_q;

    logic [RATE_W-1:0]   num_arr [NUM_ZONES];
    logic [RATE_W-1:0]   den_arr [NUM_ZONES];

    logic [DAC_W-1:0]    step_code;
    logic                step_flip;
    logic                step_rail;
    logic                zone_end;
    logic                timer_load;
    logic                timer_expired;

    // Unpack the flat per-zone rate inputs into one field per zone.
    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_rate_unpack
        assign num_arr[z] = rate_num_tab_i[z*RATE_W +: RATE_W];
        assign den_arr[z] = rate_den_tab_i[z*RATE_W +: RATE_W];
    end

    cal_step_unit #(
        .DAC_W (DAC_W)
    ) step_i (
        .code_i      (code_q),
        .above_i     (cmp_above_i),
        .ref_valid_i (ref_valid_q),
        .ref_above_i (ref_above_q),
        .next_code_o (step_code),
        .flip_o      (step_flip),
        .rail_o      (step_rail)
    );

    // A zone ends on a sample that flips polarity or hits a rail.
    assign zone_end   = (state_q == ST_SAMPLE) && (step_flip || step_rail);
    // Every DAC write restarts the settling timer.
    assign timer_load = (state_q == ST_NOMINAL) || ((state_q == ST_SAMPLE) && !zone_end);
    assign zone_nxt   = zone_q + ZONE_W'(1);

    cal_settle_timer #(
        .CNT_W (SETTLE_W)
    ) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (timer_load),
        .load_val_i (settle_q),
        .expired_o  (timer_expired)
    );

    cal_result_bank #(
        .NUM_ZONES (NUM_ZONES),
        .DAC_W     (DAC_W),
        .ZONE_W    (ZONE_W)
    ) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (zone_end),
        .wr_zone_i (zone_q),
        .wr_code_i (code_q),
        .wr_err_i  (step_rail),
        .rd_zone_i (rd_zone_i),
        .rd_code_o (rd_code_o),
        .rd_err_o  (rd_err_o)
    );

    // Main sequencer: zone order, strobes, code stepping and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            zone_q      <= '0;
            code_q      <= '0;
            nominal_q   <= '0;
            settle_q    <= '0;
            dac_wr_q    <= 1'b0;
            load_q      <= 1'b0;
            num_q       <= '0;
            den_q       <= '0;
            busy_q      <= 1'b0;
            done_q      <= 1'b0;
            ref_valid_q <= 1'b0;
            ref_above_q <= 1'b0;
        end else begin
            dac_wr_q <= 1'b0;
            load_q   <= 1'b0;
            done_q   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        nominal_q   <= nominal_code_i;
                        settle_q    <= settle_cycles_i;
                        zone_q      <= '0;
                        num_q       <= num_arr[0];
                        den_q       <= den_arr[0];
                        load_q      <= 1'b1;
                        busy_q      <= 1'b1;
                        ref_valid_q <= 1'b0;
                        state_q     <= ST_NOMINAL;
                    end
                end
                ST_NOMINAL: begin
                    code_q   <= nominal_q;
                    dac_wr_q <= 1'b1;
                    state_q  <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (timer_expired) begin
                        state_q <= ST_SAMPLE;
                    end
                end
                ST_SAMPLE: begin
                    if (zone_end) begin
                        ref_valid_q <= 1'b0;
                        if (zone_q == LAST_ZONE) begin
                            busy_q  <= 1'b0;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            zone_q  <= zone_nxt;
                            num_q   <= num_arr[zone_nxt];
                            den_q   <= den_arr[zone_nxt];
                            load_q  <= 1'b1;
                            state_q <= ST_NOMINAL;
                        end
                    end else begin
                        if (!ref_valid_q) begin
                            ref_above_q <= cmp_above_i;
                        end
                        ref_valid_q <= 1'b1;
                        code_q      <= step_code;
                        dac_wr_q    <= 1'b1;
                        state_q     <= ST_SETTLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = busy_q;
    assign done_o      = done_q;
    assign rate_load_o = load_q;
    assign rate_num_o  = num_q;
    assign rate_den_o  = den_q;
    assign dac_wr_o    = dac_wr_q;
    assign dac_code_o  = code_q;

    // R1: divider loads happen only inside a run.
    a_r1_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rate_load_o |-> busy_o);

    // R2: the cycle after a load writes the captured nominal code.
    a_r2_nominal_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        rate_load_o |=> (dac_wr_o && dac_code_o == nominal_q));

    // R3: a write not preceded by a load moves the code by exactly one LSB.
    a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_wr_o && !$past(rate_load_o)) |->
        (dac_code_o == $past(dac_code_o) + DAC_W'(1) || dac_code_o == $past(dac_code_o) - DAC_W'(1)));

    // R8: done is a single-cycle pulse and comes with busy low.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: tb/vco_dac_centering_cal_tb_top.sv
`timescale 1ns/1ps
module vco_dac_centering_cal_tb_top;

    localparam int ZONES = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  settle_in = '0;
    logic [7:0]  nominal_in = '0;
    logic [31:0] num_tab;
    logic [31:0] den_tab;
    logic        cmp_above;
    logic [1:0]  rd_zone = '0;
    logic        busy, done, rate_load, dac_wr, rd_err;
    logic [7:0]  rate_num, rate_den, dac_code, rd_code;

    int tests = 0;
    int fails = 0;
    int cur_thr = 1000;
    int thr_tab [ZONES];
    bit all_done = 1'b0;

    always #2.5 clk = ~clk;

    // Comparator model: high when the DAC code is at or above the zone threshold.
    always_comb cmp_above = (int'({24'b0, dac_code}) >= cur_thr);

    vco_dac_centering_cal dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start),
        .settle_cycles_i (settle_in), .nominal_code_i (nominal_in),
        .rate_num_tab_i (num_tab), .rate_den_tab_i (den_tab),
        .cmp_above_i (cmp_above), .rd_zone_i (rd_zone),
        .busy_o (busy), .done_o (done), .rate_load_o (rate_load),
        .rate_num_o (rate_num), .rate_den_o (rate_den),
        .dac_wr_o (dac_wr), .dac_code_o (dac_code),
        .rd_code_o (rd_code), .rd_err_o (rd_err)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected outcome of one zone from the threshold model.
    task automatic zone_model(input int nom, input int thr, output int fin, output int err,
                              output int writes, output int dir);
        if (nom >= thr) begin
            dir = -1;
            if (thr <= 0) begin fin = 0; err = 1; writes = nom + 1; end
            else begin fin = thr - 1; err = 0; writes = nom - thr + 2; end
        end else begin
            dir = 1;
            if (thr > 255) begin fin = 255; err = 1; writes = 256 - nom; end
            else begin fin = thr; err = 0; writes = thr - nom + 1; end
        end
    endtask

    // One full run with thresholds in thr_tab; optional stray start at restart_at.
    task automatic run_cal(input int settle, input int nom, input int restart_at);
        int zone = -1;
        int cyc = 0;
        int last_wr = 0;
        int last_ld = 0;
        int wcount = 0;
        int exp_code = 0;
        int fin [ZONES];
        int err [ZONES];
        int wexp [ZONES];
        int dir [ZONES];
        bit finished = 1'b0;
        settle_in  = 8'(settle);
        nominal_in = 8'(nom);
        for (int z = 0; z < ZONES; z++) zone_model(nom, thr_tab[z], fin[z], err[z], wexp[z], dir[z]);
        @(negedge clk);
        start = 1'b1;
        while (!finished && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) start = 1'b0;
            if (restart_at > 1 && cyc == restart_at) start = 1'b1;
            if (restart_at > 1 && cyc == restart_at + 1) start = 1'b0;
            if (rate_load) begin
                if (zone >= 0) chk(wcount == wexp[zone], "R5", "writes in zone", wcount, wexp[zone]);
                zone++;
                if (zone == 0) begin
                    chk(cyc == 1, "R1", "first load cycle", cyc, 1);
                    chk(busy == 1'b1, "R1", "busy at first load", busy, 1);
                end
                chk(zone < ZONES, "R7", "zone count", zone, ZONES - 1);
                if (zone < ZONES) begin
                    chk(rate_num == 8'(8'h01 + zone * 16), "R7", "numerator", rate_num, 8'h01 + zone * 16);
                    chk(rate_den == 8'(8'hA0 + zone), "R7", "denominator", rate_den, 8'hA0 + zone);
                    cur_thr = thr_tab[zone];
                end
                wcount = 0;
                last_ld = cyc;
            end
            if (dac_wr && zone >= 0 && zone < ZONES) begin
                if (wcount == 0) begin
                    chk(cyc == last_ld + 1, "R2", "nominal write cycle", cyc, last_ld + 1);
                    chk(dac_code == 8'(nom), "R2", "nominal code", dac_code, nom);
                    exp_code = nom + dir[zone];
                end else begin
                    chk(dac_code == 8'(exp_code), "R3", "stepped code", dac_code, exp_code);
                    chk(cyc - last_wr == settle + 2, "R4", "write spacing", cyc - last_wr, settle + 2);
                    exp_code = exp_code + dir[zone];
                end
                wcount++;
                last_wr = cyc;
            end
            if (done) begin
                chk(zone == ZONES - 1, "R7", "zones before done", zone, ZONES - 1);
                if (zone >= 0 && zone < ZONES)
                    chk(wcount == wexp[zone], "R5", "writes in last zone", wcount, wexp[zone]);
                chk(busy == 1'b0, "R8", "busy with done", busy, 0);
                chk(cyc - last_wr == settle + 2, "R8", "done timing", cyc - last_wr, settle + 2);
                finished = 1'b1;
            end
        end
        chk(finished, "R8", "run completed", finished, 1);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done width", done, 0);
        for (int i = 0; i < 10; i++) begin
            if (rate_load || dac_wr || busy) begin
                chk(1'b0, "R1", "activity after done", 1, 0);
                break;
            end
            @(negedge clk);
        end
        for (int z = 0; z < ZONES; z++) begin
            rd_zone = 2'(z);
            #1;
            chk(rd_code == 8'(fin[z]), err[z] ? "R6" : "R5", "stored code", rd_code, fin[z]);
            chk(rd_err == err[z][0], err[z] ? "R6" : "R5", "error flag", rd_err, err[z]);
        end
        cur_thr = 1000;
    endtask

    task automatic t_reset;
        chk(busy == 1'b0, "R9", "busy after reset", busy, 0);
        chk(done == 1'b0 && dac_wr == 1'b0 && rate_load == 1'b0, "R9", "strobes after reset", done, 0);
        for (int z = 0; z < ZONES; z++) begin
            rd_zone = 2'(z);
            #1;
            chk(rd_code == 8'd0 && rd_err == 1'b0, "R9", "cleared entry", rd_code, 0);
        end
    endtask

    task automatic t_flip_both_ways;
        thr_tab = '{100, 200, 128, 129};
        run_cal(3, 128, 0);
    endtask

    task automatic t_long_settle;
        thr_tab = '{125, 131, 120, 140};
        run_cal(20, 127, 0);
    endtask

    task automatic t_rails;
        thr_tab = '{0, 300, 6, 5};
        run_cal(0, 5, 0);
    endtask

    task automatic t_nominal_on_rail;
        thr_tab = '{0, 1, 0, 2};
        run_cal(1, 0, 0);
        thr_tab = '{300, 255, 300, 250};
        run_cal(2, 255, 0);
    endtask

    task automatic t_start_while_busy;
        thr_tab = '{90, 110, 80, 120};
        run_cal(4, 100, 9);
    endtask

    initial begin
        for (int z = 0; z < ZONES; z++) begin
            num_tab[z*8 +: 8] = 8'(8'h01 + z * 16);
            den_tab[z*8 +: 8] = 8'(8'hA0 + z);
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flip_both_ways();
        t_long_settle();
        t_rails();
        t_nominal_on_rail();
        t_start_while_busy();
        all_done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!all_done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule